// File: doc/BRIEF.md
# Interrupt distributor register bank

This block collects interrupts for a small multiprocessor system and decides which CPU sees each one. It handles a parameterised number of interrupt IDs (64 by default) and up to eight CPUs (4 by default). IDs 0 to 15 are raised only by software through a dedicated command register. Every higher ID has an input line of its own. Each ID carries an enable bit, an 8-bit priority, a CPU target mask and a two-bit configuration. The configuration selects edge or level sensing and chooses how acknowledgement is shared between CPUs.

Software reaches all state through a 32-bit word bus with a 4 KiB window. Enables and pending bits are changed only by writing ones to paired set and clear registers. Each CPU interface receives its own forwarded pending vector from the bank. It also receives the priority and target fields of every ID, and it reports acknowledge and end-of-interrupt events back as per-CPU strobes with an ID.

Top module: `irq_distributor`

## Requirements
- R1: After reset: control reads 0; every enable, pending and active bit reads 0; every priority reads 0; every target field reads all CPUs; configuration reads 2'b10 for IDs 0-15 and 2'b01 for every other ID.
- R2: Offset 0x004 is read-only. Bits [4:0] hold NUM_IRQ/32 and bits [7:5] hold NUM_CPU-1, which is 0x62 by default. Writes to it change nothing.
- R3: Word w of the enables is set at 0x100+4w and cleared at 0x180+4w, with bit b standing for ID 32w+b. Only bits written as 1 change. Both addresses read the current enables.
- R4: Word k at 0x400+4k holds the priority of ID 4k+n in bits [8n+7:8n]. Word k at 0x800+4k holds the target mask of that ID in the same byte. Only the low NUM_CPU bits of a target byte are stored, and the rest read 0.
- R5: Word k at 0xC00+4k holds the configuration of ID 16k+n in bits [2n+1:2n]. Bit 1 selects rising-edge sensing (level-high when 0). Bit 0 selects the 1-N model (N-N when 0). The fields of IDs 0-15 are read-only.
- R6: For an edge-sensed peripheral ID, a 0-to-1 change on its line makes it pending for every CPU in its target mask, from the cycle after the line is first sampled high. It stays pending after the line falls, until it is acknowledged or cleared.
- R7: A level-sensed peripheral ID is pending for its targets while its sampled line is high, and a pending-clear write cannot remove it then. One cycle after the line falls it is no longer pending, unless it was latched.
- R8: A 1 written at 0x200+4w latches the ID pending for the CPUs in its target mask. A 1 written at 0x280+4w removes the latched pending for all CPUs. Reading either address returns, per ID, the OR of its pending state over all CPUs.
- R9: cpu_irq_pend bit c*NUM_IRQ+id is high exactly when control bit 0, the enable of the ID and the pending state of the ID for CPU c are all set. Clearing control bit 0 or an enable hides the interrupt but keeps its pending state.
- R10: A write to 0xF00 latches ID wdata[3:0] pending for the CPUs chosen by wdata[25:24]. The value 0 selects the list in wdata[23:16] (bit c for CPU c, with bits at or above NUM_CPU ignored). The value 1 selects all CPUs except bus_src_cpu, 2 selects bus_src_cpu only, and 3 selects none.
- R11: An acknowledge by CPU c of an ID currently forwarded to c sets the active bit of that ID. In the 1-N model it removes the latched pending for all CPUs. In the N-N model it removes it for CPU c only. An acknowledge of an ID not forwarded to that CPU has no effect.
- R12: The active bits read at 0x300+4w, and writes there are ignored. An end-of-interrupt for an ID clears its active bit, unless an acknowledge sets the bit in the same cycle.
- R13: irq_prio bits [8id+7:8id] and irq_target bits [NUM_CPU*id+NUM_CPU-1:NUM_CPU*id] always carry the stored priority and target mask of each ID.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when 1, read when 0 |
| bus_addr | input | 12 | Byte offset in the register window |
| bus_wdata | input | 32 | Write data |
| bus_src_cpu | input | CPU_W | CPU issuing the access, used by software interrupt routing |
| bus_rdata | output | 32 | Read data in the same cycle, 0 when not reading |
| irq_lines | input | NUM_IRQ-16 | Peripheral lines, bit i is ID 16+i |
| cpu_ack_vld | input | NUM_CPU | Per-CPU acknowledge strobe |
| cpu_ack_id | input | NUM_CPU*ID_W | Per-CPU acknowledged ID |
| cpu_eoi_vld | input | NUM_CPU | Per-CPU end-of-interrupt strobe |
| cpu_eoi_id | input | NUM_CPU*ID_W | Per-CPU completed ID |
| cpu_irq_pend | output | NUM_CPU*NUM_IRQ | Forwarded pending vector per CPU |
| irq_prio | output | NUM_IRQ*8 | Priority of every ID |
| irq_target | output | NUM_IRQ*NUM_CPU | Target mask of every ID |

## Verification
The bench builds the block with its defaults, NUM_IRQ = 64 and NUM_CPU = 4. With these values every bit-per-ID register spans two words, so the word index is exercised and not only bit 0..31. Four CPUs leave the upper half of each target byte and of the software list field unused, which brings the masking of those bits within reach. Random enable, priority, target and software-interrupt traffic runs against bench models. Directed sequences then cover edge, level, 1-N and N-N handling, and the gating by the global and per-ID enables.

// File: rtl/irqd_pkg.sv
package irqd_pkg;

    // Word indices (byte offset / 4) of the register regions
    localparam int W_CTRL   = 'h000 / 4;
    localparam int W_TYPE   = 'h004 / 4;
    localparam int W_EN_SET = 'h100 / 4;
    localparam int W_EN_CLR = 'h180 / 4;
    localparam int W_PD_SET = 'h200 / 4;
    localparam int W_PD_CLR = 'h280 / 4;
    localparam int W_ACT    = 'h300 / 4;
    localparam int W_PRIO   = 'h400 / 4;
    localparam int W_TGT    = 'h800 / 4;
    localparam int W_CFG    = 'hC00 / 4;
    localparam int W_SGI    = 'hF00 / 4;

    localparam int SGI_COUNT = 16;
    localparam int PRIO_W    = 8;

    typedef enum logic [1:0] {
        ROUTE_LIST   = 2'd0,
        ROUTE_OTHERS = 2'd1,
        ROUTE_SELF   = 2'd2,
        ROUTE_NONE   = 2'd3
    } sgi_route_e;

endpackage

// File: rtl/irqd_regs.sv
module irqd_regs
    import irqd_pkg::*;
#(
    parameter int NUM_IRQ = 64,
    parameter int NUM_CPU = 4
) (
    input  logic                                     clk,
    input  logic                                     rst_n,
    input  logic                                     bus_en_i,
    input  logic                                     bus_we_i,
    input  logic [11:0]                              bus_addr_i,
    input  logic [31:0]                              bus_wdata_i,
    output logic [31:0]                              bus_rdata_o,
    input  logic [NUM_IRQ-1:0]                       pend_view_i,
    input  logic [NUM_IRQ-1:0]                       act_view_i,
    output logic                                     dist_en_o,
    output logic [NUM_IRQ-1:0]                       enable_o,
    output logic [NUM_IRQ-1:0][PRIO_W-1:0]           prio_o,
    output logic [NUM_IRQ-1:0][NUM_CPU-1:0]          tgt_o,
    output logic [NUM_IRQ-1:0][1:0]                  cfg_o,
    output logic [NUM_IRQ-1:0]                       pset_o,
    output logic [NUM_IRQ-1:0]                       pclr_o,
    output logic                                     sgi_wr_o
);

    localparam int NWORDS     = NUM_IRQ / 32;
    localparam int PRIO_WORDS = NUM_IRQ / 4;
    localparam int CFG_WORDS  = NUM_IRQ / 16;

    typedef struct packed {
        logic                            ctrl;
        logic [NUM_IRQ-1:0]              en;
        logic [NUM_IRQ-1:0][PRIO_W-1:0]  prio;
        logic [NUM_IRQ-1:0][NUM_CPU-1:0] tgt;
        logic [NUM_IRQ-1:0][1:0]         cfg;
    } regs_t;

    function automatic regs_t regs_reset();
        regs_t r;
        r = '0;
        for (int i = 0; i < NUM_IRQ; i++) begin
            r.tgt[i] = '1;
            r.cfg[i] = (i < SGI_COUNT) ? 2'b10 : 2'b01;
        end
        return r;
    endfunction

    regs_t r_d, r_q;
    int    widx;
    logic  wr;
    logic  rd;
    logic  addr_lsb_unused;

    assign widx            = int'(bus_addr_i[11:2]);
    assign wr              = bus_en_i & bus_we_i;
    assign rd              = bus_en_i & ~bus_we_i;
    assign addr_lsb_unused = ^bus_addr_i[1:0];

    always_comb begin
        r_d      = r_q;
        pset_o   = '0;
        pclr_o   = '0;
        sgi_wr_o = 1'b0;
        if (wr) begin
            if (widx == W_CTRL) r_d.ctrl = bus_wdata_i[0];
            if (widx == W_SGI)  sgi_wr_o = 1'b1;
            for (int w = 0; w < NWORDS; w++) begin
                if (widx == W_EN_SET + w)
                    r_d.en[w*32 +: 32] = r_q.en[w*32 +: 32] | bus_wdata_i;
                if (widx == W_EN_CLR + w)
                    r_d.en[w*32 +: 32] = r_q.en[w*32 +: 32] & ~bus_wdata_i;
                if (widx == W_PD_SET + w) pset_o[w*32 +: 32] = bus_wdata_i;
                if (widx == W_PD_CLR + w) pclr_o[w*32 +: 32] = bus_wdata_i;
            end
            for (int k = 0; k < PRIO_WORDS; k++) begin
                for (int n = 0; n < 4; n++) begin
                    if (widx == W_PRIO + k) r_d.prio[4*k+n] = bus_wdata_i[8*n +: PRIO_W];
                    if (widx == W_TGT + k)  r_d.tgt[4*k+n]  = bus_wdata_i[8*n +: NUM_CPU];
                end
            end
            for (int k = 0; k < CFG_WORDS; k++) begin
                for (int n = 0; n < 16; n++) begin
                    if (widx == W_CFG + k && (16*k + n) >= SGI_COUNT)
                        r_d.cfg[16*k+n] = bus_wdata_i[2*n +: 2];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= regs_reset();
        else        r_q <= r_d;
    end

    always_comb begin
        bus_rdata_o = '0;
        if (rd) begin
            if (widx == W_CTRL) bus_rdata_o[0] = r_q.ctrl;
            if (widx == W_TYPE) begin
                bus_rdata_o[4:0] = 5'(NWORDS);
                bus_rdata_o[7:5] = 3'(NUM_CPU - 1);
            end
            for (int w = 0; w < NWORDS; w++) begin
                if (widx == W_EN_SET + w || widx == W_EN_CLR + w)
                    bus_rdata_o = r_q.en[w*32 +: 32];
                if (widx == W_PD_SET + w || widx == W_PD_CLR + w)
                    bus_rdata_o = pend_view_i[w*32 +: 32];
                if (widx == W_ACT + w)
                    bus_rdata_o = act_view_i[w*32 +: 32];
            end
            for (int k = 0; k < PRIO_WORDS; k++) begin
                for (int n = 0; n < 4; n++) begin
                    if (widx == W_PRIO + k) bus_rdata_o[8*n +: PRIO_W]  = r_q.prio[4*k+n];
                    if (widx == W_TGT + k)  bus_rdata_o[8*n +: NUM_CPU] = r_q.tgt[4*k+n];
                end
            end
            for (int k = 0; k < CFG_WORDS; k++) begin
                for (int n = 0; n < 16; n++) begin
                    if (widx == W_CFG + k) bus_rdata_o[2*n +: 2] = r_q.cfg[16*k+n];
                end
            end
        end
    end

    assign dist_en_o = r_q.ctrl;
    assign enable_o  = r_q.en;
    assign prio_o    = r_q.prio;
    assign tgt_o     = r_q.tgt;
    assign cfg_o     = r_q.cfg;

    // R3: a one written to the set or clear word lands on the addressed enable bit
    for (genvar gi = 0; gi < NUM_IRQ; gi++) begin : g_en_chk
        p_en_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (wr && widx == W_EN_SET + gi / 32 && bus_wdata_i[gi % 32]) |=> r_q.en[gi]);
        p_en_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (wr && widx == W_EN_CLR + gi / 32 && bus_wdata_i[gi % 32]) |=> !r_q.en[gi]);
    end

endmodule

// File: rtl/irqd_sgi.sv
module irqd_sgi
    import irqd_pkg::*;
#(
    parameter int NUM_CPU = 4,
    parameter int CPU_W   = 2
) (
    input  logic               sgi_wr_i,
    input  logic [1:0]         route_i,
    input  logic [NUM_CPU-1:0] list_i,
    input  logic [CPU_W-1:0]   src_cpu_i,
    output logic [NUM_CPU-1:0] cpu_mask_o
);

    always_comb begin
        cpu_mask_o = '0;
        if (sgi_wr_i) begin
            case (sgi_route_e'(route_i))
                ROUTE_LIST:   cpu_mask_o = list_i;
                ROUTE_OTHERS: for (int c = 0; c < NUM_CPU; c++)
                                  cpu_mask_o[c] = (CPU_W'(c) != src_cpu_i);
                ROUTE_SELF:   for (int c = 0; c < NUM_CPU; c++)
                                  cpu_mask_o[c] = (CPU_W'(c) == src_cpu_i);
                default:      cpu_mask_o = '0;
            endcase
        end
    end

endmodule

// File: rtl/irqd_state.sv
module irqd_state
    import irqd_pkg::*;
#(
    parameter int NUM_IRQ = 64,
    parameter int NUM_CPU = 4,
    parameter int ID_W    = 6
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  dist_en_i,
    input  logic [NUM_IRQ-1:0]                    enable_i,
    input  logic [NUM_IRQ-1:0][NUM_CPU-1:0]       tgt_i,
    input  logic [NUM_IRQ-1:0][1:0]               cfg_i,
    input  logic [NUM_IRQ-SGI_COUNT-1:0]          line_i,
    input  logic [NUM_IRQ-1:0]                    pset_i,
    input  logic [NUM_IRQ-1:0]                    pclr_i,
    input  logic [NUM_CPU-1:0]                    sgi_mask_i,
    input  logic [3:0]                            sgi_id_i,
    input  logic [NUM_CPU-1:0]                    ack_vld_i,
    input  logic [NUM_CPU-1:0][ID_W-1:0]          ack_id_i,
    input  logic [NUM_CPU-1:0]                    eoi_vld_i,
    input  logic [NUM_CPU-1:0][ID_W-1:0]          eoi_id_i,
    output logic [NUM_CPU-1:0][NUM_IRQ-1:0]       fwd_o,
    output logic [NUM_IRQ-1:0]                    pend_any_o,
    output logic [NUM_IRQ-1:0]                    act_o
);

    localparam int NPER = NUM_IRQ - SGI_COUNT;

    typedef struct packed {
        logic [NUM_CPU-1:0][NUM_IRQ-1:0] latch;
        logic [NUM_IRQ-1:0]              act;
        logic [NPER-1:0]                 line;
    } st_t;

    st_t  s_d, s_q;
    logic [NUM_CPU-1:0][NUM_IRQ-1:0] eff;
    logic cfg_sgi_unused;

    assign cfg_sgi_unused = ^cfg_i[SGI_COUNT-1:0];

    // Effective pending: latched part plus the live level term
    always_comb begin
        pend_any_o = '0;
        for (int c = 0; c < NUM_CPU; c++) begin
            for (int id = 0; id < NUM_IRQ; id++) begin
                eff[c][id] = s_q.latch[c][id];
                if (id >= SGI_COUNT && !cfg_i[id][1])
                    eff[c][id] = eff[c][id] | (s_q.line[id-SGI_COUNT] & tgt_i[id][c]);
                fwd_o[c][id]   = dist_en_i & enable_i[id] & eff[c][id];
                pend_any_o[id] = pend_any_o[id] | eff[c][id];
            end
        end
    end

    always_comb begin
        s_d      = s_q;
        s_d.line = line_i;
        // removals first
        for (int id = 0; id < NUM_IRQ; id++)
            if (pclr_i[id])
                for (int c = 0; c < NUM_CPU; c++) s_d.latch[c][id] = 1'b0;
        for (int c = 0; c < NUM_CPU; c++) begin
            if (ack_vld_i[c] && int'(ack_id_i[c]) < NUM_IRQ && fwd_o[c][ack_id_i[c]]) begin
                if (cfg_i[ack_id_i[c]][0]) begin
                    for (int c2 = 0; c2 < NUM_CPU; c2++) s_d.latch[c2][ack_id_i[c]] = 1'b0;
                end else begin
                    s_d.latch[c][ack_id_i[c]] = 1'b0;
                end
            end
        end
        for (int c = 0; c < NUM_CPU; c++)
            if (eoi_vld_i[c] && int'(eoi_id_i[c]) < NUM_IRQ) s_d.act[eoi_id_i[c]] = 1'b0;
        for (int c = 0; c < NUM_CPU; c++)
            if (ack_vld_i[c] && int'(ack_id_i[c]) < NUM_IRQ && fwd_o[c][ack_id_i[c]])
                s_d.act[ack_id_i[c]] = 1'b1;
        // additions win over removals in the same cycle
        for (int id = SGI_COUNT; id < NUM_IRQ; id++) begin
            if (cfg_i[id][1] && line_i[id-SGI_COUNT] && !s_q.line[id-SGI_COUNT])
                for (int c = 0; c < NUM_CPU; c++)
                    s_d.latch[c][id] = s_d.latch[c][id] | tgt_i[id][c];
        end
        for (int id = 0; id < NUM_IRQ; id++)
            if (pset_i[id])
                for (int c = 0; c < NUM_CPU; c++)
                    s_d.latch[c][id] = s_d.latch[c][id] | tgt_i[id][c];
        for (int c = 0; c < NUM_CPU; c++)
            if (sgi_mask_i[c]) s_d.latch[c][sgi_id_i] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign act_o = s_q.act;

    // R6: a rising edge on an edge-sensed line with a target yields pending
    for (genvar gp = SGI_COUNT; gp < NUM_IRQ; gp++) begin : g_edge_chk
        p_edge_pend_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_i[gp][1] && line_i[gp-SGI_COUNT] && !s_q.line[gp-SGI_COUNT] && tgt_i[gp] != '0)
            |=> pend_any_o[gp]);
    end

    // R11 and R12: acknowledge marks active, a lone end-of-interrupt clears it
    for (genvar ga = 0; ga < NUM_IRQ; ga++) begin : g_act_chk
        for (genvar gc = 0; gc < NUM_CPU; gc++) begin : g_cpu
            p_ack_active_r11: assert property (@(posedge clk) disable iff (!rst_n)
                (ack_vld_i[gc] && ack_id_i[gc] == ID_W'(ga) && fwd_o[gc][ga]) |=> act_o[ga]);
        end
        p_eoi_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
            (eoi_vld_i[0] && eoi_id_i[0] == ID_W'(ga) && ack_vld_i == '0) |=> !act_o[ga]);
    end

endmodule

// File: rtl/irq_distributor.sv
module irq_distributor
    import irqd_pkg::*;
#(
    parameter int NUM_IRQ = 64,
    parameter int NUM_CPU = 4,
    localparam int ID_W   = $clog2(NUM_IRQ),
    localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         bus_en,
    input  logic                         bus_we,
    input  logic [11:0]                  bus_addr,
    input  logic [31:0]                  bus_wdata,
    input  logic [CPU_W-1:0]             bus_src_cpu,
    output logic [31:0]                  bus_rdata,
    input  logic [NUM_IRQ-17:0]          irq_lines,
    input  logic [NUM_CPU-1:0]           cpu_ack_vld,
    input  logic [NUM_CPU*ID_W-1:0]      cpu_ack_id,
    input  logic [NUM_CPU-1:0]           cpu_eoi_vld,
    input  logic [NUM_CPU*ID_W-1:0]      cpu_eoi_id,
    output logic [NUM_CPU*NUM_IRQ-1:0]   cpu_irq_pend,
    output logic [NUM_IRQ*8-1:0]         irq_prio,
    output logic [NUM_IRQ*NUM_CPU-1:0]   irq_target
);

    logic                                 dist_en;
    logic [NUM_IRQ-1:0]                   enable;
    logic [NUM_IRQ-1:0][PRIO_W-1:0]       prio;
    logic [NUM_IRQ-1:0][NUM_CPU-1:0]      tgt;
    logic [NUM_IRQ-1:0][1:0]              cfg;
    logic [NUM_IRQ-1:0]                   pset, pclr, pend_any, act;
    logic                                 sgi_wr;
    logic [NUM_CPU-1:0]                   sgi_mask;
    logic [NUM_CPU-1:0][NUM_IRQ-1:0]      fwd;
    logic [NUM_CPU-1:0][ID_W-1:0]         ack_id_a, eoi_id_a;

    assign ack_id_a = cpu_ack_id;
    assign eoi_id_a = cpu_eoi_id;

    irqd_regs #(.NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_en_i    (bus_en),
        .bus_we_i    (bus_we),
        .bus_addr_i  (bus_addr),
        .bus_wdata_i (bus_wdata),
        .bus_rdata_o (bus_rdata),
        .pend_view_i (pend_any),
        .act_view_i  (act),
        .dist_en_o   (dist_en),
        .enable_o    (enable),
        .prio_o      (prio),
        .tgt_o       (tgt),
        .cfg_o       (cfg),
        .pset_o      (pset),
        .pclr_o      (pclr),
        .sgi_wr_o    (sgi_wr)
    );

    irqd_sgi #(.NUM_CPU(NUM_CPU), .CPU_W(CPU_W)) u_sgi (
        .sgi_wr_i   (sgi_wr),
        .route_i    (bus_wdata[25:24]),
        .list_i     (bus_wdata[16 +: NUM_CPU]),
        .src_cpu_i  (bus_src_cpu),
        .cpu_mask_o (sgi_mask)
    );

    irqd_state #(.NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU), .ID_W(ID_W)) u_state (
        .clk        (clk),
        .rst_n      (rst_n),
        .dist_en_i  (dist_en),
        .enable_i   (enable),
        .tgt_i      (tgt),
        .cfg_i      (cfg),
        .line_i     (irq_lines),
        .pset_i     (pset),
        .pclr_i     (pclr),
        .sgi_mask_i (sgi_mask),
        .sgi_id_i   (bus_wdata[3:0]),
        .ack_vld_i  (cpu_ack_vld),
        .ack_id_i   (ack_id_a),
        .eoi_vld_i  (cpu_eoi_vld),
        .eoi_id_i   (eoi_id_a),
        .fwd_o      (fwd),
        .pend_any_o (pend_any),
        .act_o      (act)
    );

    assign cpu_irq_pend = fwd;
    assign irq_prio     = prio;
    assign irq_target   = tgt;

    // R9: with the global enable off no CPU sees anything
    p_off_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !dist_en |-> (cpu_irq_pend == '0));

    // R13: output fields follow the stored registers of the bank
    p_prio_mirror_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_prio == prio) && (irq_target == tgt));

endmodule

// File: tb/test_irq_distributor.sv
module test_irq_distributor;

    localparam int NI = 64;
    localparam int NC = 4;
    localparam int IW = 6;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 bus_en = 1'b0, bus_we = 1'b0;
    logic [11:0]          bus_addr = '0;
    logic [31:0]          bus_wdata = '0;
    logic [1:0]           bus_src = '0;
    logic [31:0]          bus_rdata;
    logic [NI-17:0]       lines = '0;
    logic [NC-1:0]        ack_vld = '0, eoi_vld = '0;
    logic [NC-1:0][IW-1:0] ack_id = '0, eoi_id = '0;
    logic [NC*NI-1:0]     pend;
    logic [NI*8-1:0]      prio_out;
    logic [NI*NC-1:0]     tgt_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    irq_distributor #(.NUM_IRQ(NI), .NUM_CPU(NC)) i_irq_distributor (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_src_cpu(bus_src),
        .bus_rdata(bus_rdata), .irq_lines(lines), .cpu_ack_vld(ack_vld),
        .cpu_ack_id(ack_id), .cpu_eoi_vld(eoi_vld), .cpu_eoi_id(eoi_id),
        .cpu_irq_pend(pend), .irq_prio(prio_out), .irq_target(tgt_out)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [1:0] src = 2'd0);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_src = src;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_en = 1'b0;
    endtask

    task automatic rdchk(input string req, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        chk(req, d, exp);
    endtask

    task automatic ack(input int c, input int id);
        @(negedge clk);
        ack_vld[c] = 1'b1; ack_id[c] = IW'(id);
        @(negedge clk);
        ack_vld = '0;
    endtask

    task automatic eoi(input int c, input int id);
        @(negedge clk);
        eoi_vld[c] = 1'b1; eoi_id[c] = IW'(id);
        @(negedge clk);
        eoi_vld = '0;
    endtask

    task automatic clear_all();
        wr(12'h280, 32'hFFFF_FFFF);
        wr(12'h284, 32'hFFFF_FFFF);
    endtask

    function automatic logic [NC-1:0] sgi_targets(input int route, input logic [7:0] list, input int src);
        logic [NC-1:0] m = '0;
        for (int c = 0; c < NC; c++) begin
            if (route == 0) m[c] = list[c];
            else if (route == 1) m[c] = (c != src);
            else if (route == 2) m[c] = (c == src);
        end
        return m;
    endfunction

    function automatic logic [NC*NI-1:0] pend_vec(input logic [NC-1:0] m, input int id);
        logic [NC*NI-1:0] v = '0;
        for (int c = 0; c < NC; c++) if (m[c]) v[c*NI + id] = 1'b1;
        return v;
    endfunction

    logic [63:0] en_m;
    logic [7:0]  prio_m [NI];
    logic [NC-1:0] tgt_m [NI];

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d, e;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rdchk("R1 ctrl", 12'h000, 32'h0);
        rdchk("R1 enable", 12'h104, 32'h0);
        rdchk("R1 pending", 12'h200, 32'h0);
        rdchk("R1 active", 12'h304, 32'h0);
        rdchk("R1 prio", 12'h41C, 32'h0);
        rdchk("R1 target", 12'h800, 32'h0F0F_0F0F);
        rdchk("R1 cfg sgi", 12'hC00, 32'hAAAA_AAAA);
        rdchk("R1 cfg periph", 12'hC04, 32'h5555_5555);
        // R2 type register
        rdchk("R2 type", 12'h004, 32'h62);
        wr(12'h004, 32'hFFFF_FFFF);
        rdchk("R2 type after write", 12'h004, 32'h62);

        // R3 random enable set/clear
        en_m = '0;
        for (int i = 0; i < 24; i++) begin
            int w = $urandom % 2;
            logic [31:0] v = $urandom;
            if ($urandom % 2) begin
                wr(12'h180 + 12'(4*w), v); en_m[w*32 +: 32] &= ~v;
            end else begin
                wr(12'h100 + 12'(4*w), v); en_m[w*32 +: 32] |= v;
            end
            rdchk("R3 set view", 12'h100 + 12'(4*w), en_m[w*32 +: 32]);
            rdchk("R3 clear view", 12'h180 + 12'(4*w), en_m[w*32 +: 32]);
        end

        // R4 / R13 random priority and target
        for (int i = 0; i < NI; i++) begin prio_m[i] = '0; tgt_m[i] = '1; end
        for (int i = 0; i < 30; i++) begin
            int k = $urandom % 16;
            logic [31:0] v = $urandom;
            wr(12'h400 + 12'(4*k), v);
            for (int n = 0; n < 4; n++) prio_m[4*k+n] = v[8*n +: 8];
            rdchk("R4 prio", 12'h400 + 12'(4*k), v);
            v = $urandom;
            wr(12'h800 + 12'(4*k), v);
            for (int n = 0; n < 4; n++) tgt_m[4*k+n] = v[8*n +: NC];
            rdchk("R4 target", 12'h800 + 12'(4*k), v & 32'h0F0F_0F0F);
        end
        begin
            logic [NI*8-1:0] ep;
            logic [NI*NC-1:0] et;
            for (int i = 0; i < NI; i++) begin ep[8*i +: 8] = prio_m[i]; et[NC*i +: NC] = tgt_m[i]; end
            @(negedge clk);
            chk("R13 prio port", prio_out, ep);
            chk("R13 target port", tgt_out, et);
        end

        // R5 configuration
        wr(12'hC00, 32'hFFFF_FFFF);
        rdchk("R5 sgi cfg read-only", 12'hC00, 32'hAAAA_AAAA);
        wr(12'hC04, 32'h5555_5755);   // ID 20 edge, 1-N
        wr(12'hC08, 32'h5555_5559);   // ID 33 edge, N-N; ID 40 level, 1-N
        rdchk("R5 cfg word1", 12'hC04, 32'h5555_5755);
        rdchk("R5 cfg word2", 12'hC08, 32'h5555_5559);
        for (int k = 0; k < 16; k++) wr(12'h800 + 12'(4*k), 32'h0F0F_0F0F);
        wr(12'h814, 32'h0F0F_0F03);   // ID 20 -> CPU0,1
        wr(12'h828, 32'h0F0F_0F04);   // ID 40 -> CPU2
        wr(12'h100, 32'hFFFF_FFFF);
        wr(12'h104, 32'hFFFF_FFFF);
        wr(12'h000, 32'h1);
        @(negedge clk);
        chk("R1 nothing pending", pend, '0);

        // R6 edge, 1-N
        lines[4] = 1'b1;
        @(negedge clk);
        chk("R6 edge pending", pend, pend_vec(4'b0011, 20));
        lines[4] = 1'b0;
        @(negedge clk);
        chk("R6 edge held", pend, pend_vec(4'b0011, 20));
        ack(3, 20);
        rdchk("R11 ignored ack", 12'h300, 32'h0);
        ack(1, 20);
        chk("R11 1-N clears all", pend, '0);
        rdchk("R12 active set", 12'h300, 32'h0010_0000);
        wr(12'h300, 32'h0);
        rdchk("R12 active read-only", 12'h300, 32'h0010_0000);
        eoi(1, 20);
        rdchk("R12 eoi clears", 12'h300, 32'h0);

        // R11 N-N via ID 33
        lines[17] = 1'b1;
        @(negedge clk);
        lines[17] = 1'b0;
        chk("R6 edge all targets", pend, pend_vec(4'b1111, 33));
        ack(2, 33);
        chk("R11 N-N keeps others", pend, pend_vec(4'b1011, 33));
        rdchk("R11 active", 12'h304, 32'h0000_0002);
        wr(12'h284, 32'h0000_0002);
        chk("R8 pending clear", pend, '0);
        eoi(2, 33);

        // R7 level via ID 40
        lines[24] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R7 level pending", pend, pend_vec(4'b0100, 40));
        wr(12'h284, 32'h0000_0100);
        chk("R7 clear ignored while high", pend, pend_vec(4'b0100, 40));
        lines[24] = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R7 level drops", pend, '0);

        // R8 pending set latches
        wr(12'h204, 32'h0000_0100);
        rdchk("R8 pending read", 12'h204, 32'h0000_0100);
        chk("R8 pending set", pend, pend_vec(4'b0100, 40));
        clear_all();

        // R9 gating
        wr(12'h200, 32'h0010_0000);
        chk("R9 forwarded", pend, pend_vec(4'b0011, 20));
        wr(12'h000, 32'h0);
        chk("R9 disabled silent", pend, '0);
        rdchk("R9 state kept", 12'h200, 32'h0010_0000);
        wr(12'h000, 32'h1);
        chk("R9 re-enabled", pend, pend_vec(4'b0011, 20));
        wr(12'h180, 32'h0010_0000);
        chk("R9 per-ID disable", pend, '0);
        wr(12'h100, 32'h0010_0000);
        chk("R9 per-ID re-enable", pend, pend_vec(4'b0011, 20));
        clear_all();

        // R10 directed software interrupts
        wr(12'hF00, 32'h00FA_0005);
        chk("R10 list", pend, pend_vec(4'b1010, 5));
        ack(1, 5);
        chk("R11 sgi N-N", pend, pend_vec(4'b1000, 5));
        eoi(1, 5);
        clear_all();
        wr(12'hF00, 32'h0300_0009, 2'd0);
        chk("R10 reserved route", pend, '0);

        // R10 random software interrupts
        for (int i = 0; i < 20; i++) begin
            int rt = $urandom % 4;
            logic [7:0] ls = 8'($urandom);
            int id = $urandom % 16;
            int src = $urandom % 4;
            clear_all();
            wr(12'hF00, (32'(rt) << 24) | (32'(ls) << 16) | 32'(id), 2'(src));
            chk("R10 route", pend, pend_vec(sgi_targets(rt, ls, src), id));
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule